// File: doc/BRIEF.md
# Buffered Variable-Period PWM Channel

This block produces one pulse-width-modulated output. The system clock is first halved. A 16-bit prescaler then divides it further and produces a count tick. Each tick advances an 8-bit counter. The counter is compared against an active width value and an active period value. A period starts when the counter returns to zero. The output is active while the counter is below the width, and inactive from the width up to the period.

Software writes five byte-wide registers through a single-cycle write strobe:

- prescaler low byte
- prescaler high byte
- pulse width
- period
- control (enable and polarity)

Writes to the prescaler, width and period go to staging registers. The running channel never sees a half-updated setting. The staged set moves into the active registers as one unit, either when the channel is enabled or when the current period ends. A staged set with an illegal period is refused, the previous active set is kept, and an error flag is raised.

Top module: `pwm_vperiod_chan`

## Requirements
- R1: After a synchronous active-low reset, `pwm_out` is 0 and `cfg_err` is 0. The channel is disabled with normal polarity.
- R2: With active prescaler value P, the counter advances once every 2*(P+1) clock cycles. With active period value N, one full period lasts (N+1)*2*(P+1) cycles.
- R3: Within a period, the active level lasts W*2*(P+1) cycles, where W is the active width, and the inactive level fills the rest. When W is 0 the output never reaches the active level.
- R4: Control register (address 4) bit 1 selects polarity. When it is 0 the active level is 1. When it is 1 the output is inverted, so the active level is 0.
- R5: Control bit 0 enables the channel. While it is clear, the counter and prescaler are held at zero and `pwm_out` sits at the inactive level: 0, or 1 when inverted. Enabling again starts a fresh period.
- R6: Width (address 2) and period (address 3) written while the channel runs do not change the period in progress. They take effect from the next period.
- R7: The write that sets control bit 0 while the channel is disabled loads the staged set at once. The output is active from the next cycle, and the first period already has the new timing.
- R8: Writing the prescaler high byte (address 1) only fills a hold register. The following low-byte write (address 0) moves the hold byte and the low byte together into the staged 16-bit prescaler.
- R9: A staged set is legal only if its period is nonzero and greater than its width. An illegal set is refused at enable or at a period end. When that happens, the active values are kept and `cfg_err` becomes 1. A later legal commit clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register select: 0 prescaler low, 1 prescaler high, 2 width, 3 period, 4 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| cfg_err | output | 1 | Set when a staged set was refused; cleared by a legal commit |

## Verification
Every internal fault in this block shows up as a change in run lengths on `pwm_out`. A wrong divide count, compare or wrap changes the high or low length of the very next period. A commit at the wrong moment changes either the period in progress or the one after a write, instead of exactly the one after the boundary. Because of this, a scoreboard of expected high and low lengths per period catches such a fault within one or two periods. A validation fault shows up as a wrong `cfg_err` value after the first boundary that follows an illegal or legal write, and as a period length that should not have changed.

// File: rtl/pwm_vp_pkg.sv
// Package: shared constants and register select codes for the PWM channel.
// Assumes byte-wide software writes; the prescaler spans two bytes.
package pwm_vp_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PRE_LO = 3'd0,
        SEL_PRE_HI = 3'd1,
        SEL_WIDTH  = 3'd2,
        SEL_PERIOD = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_INV_BIT = 1;
endpackage

// File: rtl/pwm_shadow_regs.sv
// Staging and active register sets for the PWM channel.
// Software writes land in staging registers. The whole staged set is copied
// into the active set on enable or at a period boundary, but only when legal
// (period nonzero and above width). Otherwise the active set is kept and an
// error flag is raised. Assumes `boundary` pulses only while enabled.
module pwm_shadow_regs
    import pwm_vp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              boundary,
    output logic              en_q,
    output logic              inv_q,
    output logic [PRE_W-1:0]  act_pre,
    output logic [CNT_W-1:0]  act_wid,
    output logic [CNT_W-1:0]  act_per,
    output logic              cfg_err
);
    localparam int HOLD_W = PRE_W - DATA_W;

    logic [HOLD_W-1:0] hold_hi;
    logic [PRE_W-1:0]  stg_pre;
    logic [CNT_W-1:0]  stg_wid;
    logic [CNT_W-1:0]  stg_per;
    logic              stg_ok;
    logic              load_req;
    logic              ctl_wr;
    logic              unused_ctl_bits;

    assign ctl_wr          = wr_en && (wr_addr == SEL_CTRL);
    assign unused_ctl_bits = ^wr_data[DATA_W-1:2];
    assign stg_ok          = (stg_per != '0) && (stg_per > stg_wid);
    assign load_req        = (ctl_wr && wr_data[CTRL_EN_BIT] && !en_q)
                           || (boundary && en_q);

    // Staging registers: capture software writes, high byte via hold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_hi <= '0;
            stg_pre <= '0;
            stg_wid <= '0;
            stg_per <= '1;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_PRE_LO: stg_pre <= {hold_hi, wr_data};
                SEL_PRE_HI: hold_hi <= wr_data[HOLD_W-1:0];
                SEL_WIDTH:  stg_wid <= wr_data[CNT_W-1:0];
                SEL_PERIOD: stg_per <= wr_data[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // Control bits: take effect on the write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            inv_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q  <= wr_data[CTRL_EN_BIT];
            inv_q <= wr_data[CTRL_INV_BIT];
        end
    end

    // Active set: commit the whole staged set when legal, else flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre <= '0;
            act_wid <= '0;
            act_per <= '1;
            cfg_err <= 1'b0;
        end else if (load_req) begin
            if (stg_ok) begin
                act_pre <= stg_pre;
                act_wid <= stg_wid;
                act_per <= stg_per;
                cfg_err <= 1'b0;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

    assert_active_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> ((act_per != '0) && (act_per > act_wid)));
    assert_err_keeps_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($stable(act_per) && $stable(act_wid) && $stable(act_pre)));
    assert_hi_byte_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_PRE_HI) |=> $stable(stg_pre));
endmodule

// File: rtl/pwm_tick_gen.sv
// Count tick generator: a toggle stage halves the clock, then a prescale
// counter emits one tick every (act_pre+1) half-rate steps. Held at zero
// while disabled. Assumes act_pre only changes when a tick wraps the counter
// or while the channel is starting.
module pwm_tick_gen #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] act_pre,
    output logic             tick
);
    logic             half;
    logic [PRE_W-1:0] pcnt;
    logic             pre_hit;

    assign pre_hit = (pcnt == act_pre);
    assign tick    = en && half && pre_hit;

    // Divide-by-two stage: alternates every clock while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) half <= 1'b0;
        else               half <= ~half;
    end

    // Prescale counter: steps on half-rate phases, wraps on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pcnt <= '0;
        else if (half)     pcnt <= pre_hit ? '0 : pcnt + PRE_W'(1);
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_no_tick_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);
endmodule

// File: rtl/pwm_cmp_core.sv
// Period counter and output compare. The counter advances on each tick and
// clears when it equals the active period, which marks the boundary. The
// output is active below the active width and follows the polarity bit.
// Assumes active values change only at the boundary or on enable.
module pwm_cmp_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inv,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_wid,
    input  logic [CNT_W-1:0] act_per,
    output logic             boundary,
    output logic             pwm_out
);
    logic [CNT_W-1:0] cnt;
    logic             active_lvl;

    assign boundary   = tick && (cnt == act_per);
    assign active_lvl = en && (cnt < act_wid);
    assign pwm_out    = active_lvl ^ inv;

    // Period counter: clears at the boundary, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= (cnt == act_per) ? '0 : cnt + CNT_W'(1);
    end

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= act_per));
    assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (cnt == '0));
    assert_idle_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/pwm_vperiod_chan.sv
// Top level of the buffered variable-period PWM channel: joins the register
// sets, the tick generator and the compare core. Assumes one write per
// wr_en cycle and a synchronous active-low reset.
module pwm_vperiod_chan
    import pwm_vp_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              cfg_err
);
    localparam int PRE_W = 2 * DATA_W;

    logic             en_q;
    logic             inv_q;
    logic [PRE_W-1:0] act_pre;
    logic [CNT_W-1:0] act_wid;
    logic [CNT_W-1:0] act_per;
    logic             tick;
    logic             boundary;

    pwm_shadow_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .boundary(boundary), .en_q(en_q), .inv_q(inv_q),
        .act_pre(act_pre), .act_wid(act_wid), .act_per(act_per),
        .cfg_err(cfg_err)
    );

    pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_q), .act_pre(act_pre), .tick(tick)
    );

    pwm_cmp_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_q), .inv(inv_q), .tick(tick),
        .act_wid(act_wid), .act_per(act_per), .boundary(boundary),
        .pwm_out(pwm_out)
    );

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !tick) |-> (pwm_out == inv_q));
endmodule

// File: tb/tb_pwm_vperiod_chan.sv
// Scoreboard bench: the driver pushes expected (active, inactive) run
// lengths per period; a monitor measures them on pwm_out and compares.
module tb_pwm_vperiod_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;
    logic       cfg_err;

    typedef struct {
        int    act_len;
        int    idle_len;
        string req;
    } period_t;

    period_t exp_q[$];
    int      checks = 0;
    int      failures = 0;
    bit      mon_arm = 1'b0;
    bit      tb_inv = 1'b0;

    always #2.5 clk = ~clk;

    pwm_vperiod_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int hi, input int lo, input string req, input int n);
        for (int i = 0; i < n; i++) begin
            period_t it;
            it.act_len = hi; it.idle_len = lo; it.req = req;
            exp_q.push_back(it);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic measure_active(output int n);
        n = 0;
        while (pwm_out ^ tb_inv) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Monitor: measure run lengths between active-level rises and score them.
    int  m_hi = 0;
    int  m_lo = 0;
    bit  m_sync = 1'b0;
    bit  m_prev = 1'b0;
    always @(negedge clk) begin
        bit lvl;
        lvl = pwm_out ^ tb_inv;
        if (!mon_arm) begin
            m_sync = 1'b0; m_hi = 0; m_lo = 0;
        end else if (lvl && !m_prev) begin
            if (m_sync && exp_q.size() > 0) begin
                period_t it;
                it = exp_q.pop_front();
                chk(m_hi == it.act_len, it.req, m_hi, it.act_len, "active run length");
                chk(m_lo == it.idle_len, it.req, m_lo, it.idle_len, "inactive run length");
            end
            m_sync = 1'b1; m_hi = 1; m_lo = 0;
        end else if (lvl) begin
            m_hi++;
        end else begin
            m_lo++;
        end
        m_prev = lvl;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R2 watchdog expired: actual=hang expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Driver: scenarios in sequence.
    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1", pwm_out, 0, "reset output");
        chk(cfg_err == 1'b0, "R1", cfg_err, 0, "reset error flag");

        // Fastest rate, normal polarity: P=0, W=3, N=9 -> unit 2.
        wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'd3); wr(3'd3, 8'd9);
        chk(pwm_out == 1'b0, "R5", pwm_out, 0, "disabled output normal polarity");
        wr(3'd4, 8'h01);
        measure_active(n);
        chk(n == 6, "R7", n, 6, "first period active length after enable");
        mon_arm = 1'b1;
        push(6, 14, "R2", 3);
        drain();
        mon_arm = 1'b0;

        // Inverted polarity: P=2, W=5, N=7 -> unit 6.
        wr(3'd4, 8'h02);
        tb_inv = 1'b1;
        chk(pwm_out == 1'b1, "R4", pwm_out, 1, "disabled output inverted polarity");
        wr(3'd0, 8'd2); wr(3'd2, 8'd5); wr(3'd3, 8'd7);
        wr(3'd4, 8'h03);
        measure_active(n);
        chk(n == 30, "R4", n, 30, "inverted first active length");
        mon_arm = 1'b1;
        push(30, 18, "R3", 2);
        drain();

        // Mid-period rewrite: old period finishes, then W=2, N=4.
        push(30, 18, "R6", 1);
        push(12, 18, "R6", 2);
        wr(3'd2, 8'd2); wr(3'd3, 8'd4);
        drain();

        // High byte alone must not change the prescaler.
        wr(3'd1, 8'h01);
        push(12, 18, "R8", 2);
        drain();
        // Low byte completes it: P=0x0100 -> unit 514.
        push(12, 18, "R8", 1);
        push(1028, 1542, "R8", 2);
        wr(3'd0, 8'h00);
        drain();

        // Illegal period (N=1 <= W=2) is refused.
        wr(3'd3, 8'd1);
        push(1028, 1542, "R9", 2);
        drain();
        chk(cfg_err == 1'b1, "R9", cfg_err, 1, "error flag after refused set");
        wr(3'd3, 8'd4);
        push(1028, 1542, "R9", 1);
        drain();
        chk(cfg_err == 1'b0, "R9", cfg_err, 0, "error flag cleared by legal commit");
        mon_arm = 1'b0;

        // Disable, width zero: never active.
        wr(3'd4, 8'h00);
        tb_inv = 1'b0;
        chk(pwm_out == 1'b0, "R5", pwm_out, 0, "output after disable");
        wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'd0); wr(3'd3, 8'd5);
        wr(3'd4, 8'h01);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
        chk(n == 0, "R3", n, 0, "active cycles with zero width");
        chk(cfg_err == 1'b0, "R7", cfg_err, 0, "legal enable commit");

        // Restart with near-full width: W=254, N=255, P=0.
        wr(3'd4, 8'h00);
        wr(3'd3, 8'd255); wr(3'd2, 8'd254);
        wr(3'd4, 8'h01);
        measure_active(n);
        chk(n == 508, "R5", n, 508, "fresh period after re-enable");
        mon_arm = 1'b1;
        push(508, 4, "R2", 2);
        drain();
        mon_arm = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule